// File: doc/BRIEF.md
# Serial Flash Sequential Read Controller

The controller turns a one-cycle read strobe into a standard sequential read on a single-bit SPI serial flash. It pulls chip select low, shifts out the read opcode and the start address, and then collects bytes from the data line one after another. Each byte is placed on a parallel output together with its flash address. A one-cycle valid pulse tells the consumer to take the byte.

The length of a burst is not given in advance. The consumer holds the continuation input high for as long as it wants more bytes. Once that input is seen low, the controller fetches exactly one more byte and then ends the command. A single command can stream the whole device. The last byte and its address stay on the outputs until the next command or a reset.

Top module: `sflash_seq_read`

## Requirements
- R1: When `rd_start` is high at a rising clock edge while `busy` is low, the command is accepted. From the next cycle `busy` is high and `flash_cs_n` is low. The flash then receives the opcode 0x03 followed by the AW-bit start address, all most significant bit first, over the first 8+AW rising edges of `flash_sck`.
- R2: `flash_sck` is low whenever chip select is high. While the command runs it toggles at the input clock rate: `flash_mosi` changes on its falling edge and `flash_miso` is sampled on its rising edge. Each data byte arrives most significant bit first. A burst of n bytes uses exactly 8+AW+8n rising edges.
- R3: The first byte appears on `byte_out` at clock edge 8+AW+8 after the accept edge. `byte_vld` is still low in the cycle that follows that edge.
- R4: `byte_vld` is high for exactly one cycle per byte. It rises one edge after the byte has been placed on `byte_out`, so the first pulse starts at edge 8+AW+9 after the accept edge. Later pulses follow at 8-cycle intervals.
- R5: While `byte_vld` is high, `byte_addr` holds the flash address of `byte_out`. The addresses of a burst run consecutively from the start address and wrap modulo 2^AW.
- R6: While `rd_cont` stays high, bytes keep streaming with no new command.
- R7: When `rd_cont` is seen low after the valid pulse of byte n-2, the burst delivers byte n-1 with its own valid pulse and then stops, so exactly n bytes are delivered.
- R8: A single byte is delivered in either of two cases. In the first, `rd_cont` is high only in the strobe cycle. In the second, `rd_cont` is seen low at any edge up to and including the edge that completes the first byte.
- R9: Chip select returns high at the same edge at which the final valid pulse rises. `busy` stays high through that pulse and falls together with it.
- R10: After a burst ends, `byte_out` and `byte_addr` keep the last byte and its address until a new command is accepted.
- R11: A read strobe that arrives while `busy` is high is ignored: it starts no second command and does not change the running address sequence.
- R12: After reset, `busy` and `byte_vld` are low, chip select is high, `flash_mosi` is low, and `byte_out` and `byte_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; also the source of the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_start | input | 1 | Read strobe, sampled at the rising edge |
| rd_cont | input | 1 | Continuation level; low requests the end of the burst |
| start_addr | input | AW | Flash start address, sampled with the strobe |
| byte_out | output | 8 | Most recent byte read |
| byte_vld | output | 1 | One-cycle pulse per delivered byte |
| byte_addr | output | AW | Flash address of `byte_out` |
| busy | output | 1 | High while a command is in progress |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_sck | output | 1 | Flash serial clock |
| flash_mosi | output | 1 | Serial data to the flash |
| flash_miso | input | 1 | Serial data from the flash |

## Verification
With the accept edge counted as edge 0 and AW = 24, `byte_out` is due at edge 40, the first `byte_vld` at edge 41, and each later pulse 8 edges after the one before. Chip select rises at the edge of the final pulse, and `busy` falls one edge after it. The bench drives every input on the falling clock edge and keeps a counter of edges since acceptance. It samples each output on the falling edge after the edge where the result is due, and compares the counter value at every valid pulse with the expected schedule. A behavioural flash model records the command word and counts serial clock rises and chip-select falls. This lets the bench check the command encoding, the point where the clock stops and whether a strobe was ignored after each burst.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_FIN,
    ST_DRAIN
  } sfr_state_t;

  localparam logic [7:0] RD_OPCODE = 8'h03;

  // number of command bits sent before the first data bit
  function automatic int cmd_bits(input int aw);
    return 8 + aw;
  endfunction

endpackage

// File: rtl/sfr_seq.sv
module sfr_seq
  import sfr_pkg::*;
#(
  parameter int CB = 32,
  localparam int CW = $clog2(CB + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_start,
  input  logic       rd_cont,
  output logic       accept_ev,
  output logic       shift_ev,
  output logic       sample_ev,
  output logic       byte_ev,
  output logic       final_ev,
  output logic       sck_run,
  output logic       cs_n,
  output logic       busy
);

  sfr_state_t     state_q;
  logic [CW-1:0]  cmd_cnt_q;
  logic [2:0]     bit_q;
  logic           end_req_q;

  assign accept_ev = (state_q == ST_IDLE) && rd_start;
  assign shift_ev  = (state_q == ST_CMD);
  assign sample_ev = (state_q == ST_DATA);
  assign byte_ev   = sample_ev && (bit_q == 3'd7);
  assign final_ev  = byte_ev && (end_req_q || !rd_cont);
  assign sck_run   = shift_ev || sample_ev;
  assign busy      = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cmd_cnt_q <= '0;
      bit_q     <= '0;
      end_req_q <= 1'b0;
      cs_n      <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (rd_start) begin
            state_q   <= ST_CMD;
            cmd_cnt_q <= '0;
            bit_q     <= '0;
            end_req_q <= !rd_cont;
            cs_n      <= 1'b0;
          end
        end
        ST_CMD: begin
          if (!rd_cont) end_req_q <= 1'b1;
          if (cmd_cnt_q == CW'(CB - 1)) begin
            state_q   <= ST_DATA;
            cmd_cnt_q <= '0;
          end else begin
            cmd_cnt_q <= cmd_cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (!rd_cont) end_req_q <= 1'b1;
          bit_q <= bit_q + 1'b1;
          if (final_ev) state_q <= ST_FIN;
        end
        ST_FIN: begin
          cs_n    <= 1'b1;
          state_q <= ST_DRAIN;
        end
        ST_DRAIN: begin
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sfr_cmd_tx.sv
module sfr_cmd_tx
  import sfr_pkg::*;
#(
  parameter int AW = 24,
  localparam int CB = cmd_bits(AW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          shift,
  input  logic          run,
  input  logic [AW-1:0] addr,
  output logic          sck_en,
  output logic          mosi
);

  logic [CB-1:0] cmd_sr_q;

  function automatic logic [CB-1:0] cmd_word(input logic [AW-1:0] a);
    return {RD_OPCODE, a};
  endfunction

  // command word advances at each serial clock rise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_sr_q <= '0;
    end else if (load) begin
      cmd_sr_q <= cmd_word(addr);
    end else if (shift) begin
      cmd_sr_q <= {cmd_sr_q[CB-2:0], 1'b0};
    end
  end

  // falling-edge launch: MOSI and the serial clock gate change while clk is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_en <= 1'b0;
      mosi   <= 1'b0;
    end else begin
      sck_en <= run;
      mosi   <= run ? cmd_sr_q[CB-1] : 1'b0;
    end
  end

endmodule

// File: rtl/sfr_rx.sv
module sfr_rx #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          sample,
  input  logic          byte_done,
  input  logic [AW-1:0] addr,
  input  logic          miso,
  output logic [7:0]    byte_out,
  output logic          byte_vld,
  output logic [AW-1:0] byte_addr
);

  logic [6:0]    sh_q;
  logic [AW-1:0] cur_addr_q;
  logic          done_q;

  function automatic logic [AW-1:0] addr_succ(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q       <= '0;
      cur_addr_q <= '0;
      done_q     <= 1'b0;
      byte_vld   <= 1'b0;
      byte_out   <= '0;
      byte_addr  <= '0;
    end else begin
      done_q   <= byte_done;
      byte_vld <= done_q;
      if (load) begin
        cur_addr_q <= addr;
      end
      if (sample) begin
        sh_q <= {sh_q[5:0], miso};
      end
      if (byte_done) begin
        byte_out   <= {sh_q, miso};
        byte_addr  <= cur_addr_q;
        cur_addr_q <= addr_succ(cur_addr_q);
      end
    end
  end

endmodule

// File: rtl/sflash_seq_read.sv
module sflash_seq_read
  import sfr_pkg::*;
#(
  parameter bit  WIDE_ADDR = 1'b0,
  localparam int AW = WIDE_ADDR ? 32 : 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_start,
  input  logic          rd_cont,
  input  logic [AW-1:0] start_addr,
  output logic [7:0]    byte_out,
  output logic          byte_vld,
  output logic [AW-1:0] byte_addr,
  output logic          busy,
  output logic          flash_cs_n,
  output logic          flash_sck,
  output logic          flash_mosi,
  input  logic          flash_miso
);

  localparam int CB = cmd_bits(AW);

  // internal events, named for the checker
  logic accept_ev;
  logic shift_ev;
  logic sample_ev;
  logic byte_ev;
  logic final_ev;
  logic sck_run;
  logic sck_en;

  sfr_seq #(.CB(CB)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_start  (rd_start),
    .rd_cont   (rd_cont),
    .accept_ev (accept_ev),
    .shift_ev  (shift_ev),
    .sample_ev (sample_ev),
    .byte_ev   (byte_ev),
    .final_ev  (final_ev),
    .sck_run   (sck_run),
    .cs_n      (flash_cs_n),
    .busy      (busy)
  );

  sfr_cmd_tx #(.AW(AW)) u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept_ev),
    .shift  (shift_ev),
    .run    (sck_run),
    .addr   (start_addr),
    .sck_en (sck_en),
    .mosi   (flash_mosi)
  );

  sfr_rx #(.AW(AW)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept_ev),
    .sample    (sample_ev),
    .byte_done (byte_ev),
    .addr      (start_addr),
    .miso      (flash_miso),
    .byte_out  (byte_out),
    .byte_vld  (byte_vld),
    .byte_addr (byte_addr)
  );

  // gate enable changes only while clk is low, so the serial clock has full pulses
  assign flash_sck = clk & sck_en;

endmodule

// File: rtl/sfr_checker.sv
module sfr_checker #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_start,
  input logic          busy,
  input logic          byte_vld,
  input logic [7:0]    byte_out,
  input logic [AW-1:0] byte_addr,
  input logic          cs_n,
  input logic          sck_en,
  input logic          final_ev
);

  logic          seen_q;
  logic [AW-1:0] prev_addr_q;
  logic [3:0]    gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q      <= 1'b0;
      prev_addr_q <= '0;
      gap_q       <= '0;
    end else begin
      if (!busy) begin
        seen_q <= 1'b0;
      end else if (byte_vld) begin
        seen_q <= 1'b1;
      end
      if (byte_vld) begin
        prev_addr_q <= byte_addr;
        gap_q       <= '0;
      end else if (gap_q != 4'hF) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  // R1: an accepted strobe raises busy and selects the flash
  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start && !busy |=> busy && !cs_n);

  // R2: no serial clock while deselected
  p_sck_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck_en);

  // R4: valid is a single-cycle pulse
  p_vld_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);

  // R4: pulses within a burst are eight cycles apart
  p_byte_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && seen_q |-> gap_q == 4'd7);

  // R5: addresses within a burst are consecutive
  p_consec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && seen_q |-> byte_addr == prev_addr_q + AW'(1));

  // R9: valid only while busy, and busy ends with chip select high
  p_vld_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> busy);
  p_cs_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);
  p_final_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    final_ev |=> !cs_n ##1 cs_n);

  // R10: outputs hold while idle
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(byte_out) && $stable(byte_addr));

endmodule

bind sflash_seq_read sfr_checker #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_start  (rd_start),
  .busy      (busy),
  .byte_vld  (byte_vld),
  .byte_out  (byte_out),
  .byte_addr (byte_addr),
  .cs_n      (flash_cs_n),
  .sck_en    (sck_en),
  .final_ev  (final_ev)
);

// File: tb/sflash_seq_read_test.sv
`timescale 1ns/1ps
module sflash_seq_read_test;

  localparam int AW      = 24;
  localparam int CB      = 8 + AW;
  localparam int T_DATA  = CB + 8;
  localparam int T_VLD   = CB + 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_start = 1'b0;
  logic          rd_cont = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [7:0]    byte_out;
  logic          byte_vld;
  logic [AW-1:0] byte_addr;
  logic          busy;
  logic          cs_n;
  logic          sck;
  logic          mosi;
  logic          miso = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sflash_seq_read uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_start   (rd_start),
    .rd_cont    (rd_cont),
    .start_addr (start_addr),
    .byte_out   (byte_out),
    .byte_vld   (byte_vld),
    .byte_addr  (byte_addr),
    .busy       (busy),
    .flash_cs_n (cs_n),
    .flash_sck  (sck),
    .flash_mosi (mosi),
    .flash_miso (miso)
  );

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    return (a[7:0] * 8'd13) ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h3C;
  endfunction

  // ---------------- flash model ----------------
  logic [CB-1:0] fl_cmd = '0;
  logic [CB-1:0] last_cmd = '0;
  int fl_bits = 0;
  int fl_rises = 0;
  int last_rises = 0;
  int fl_dbit = 0;
  int cs_falls = 0;

  always @(posedge sck or posedge cs_n) begin
    if (cs_n) begin
      last_cmd   = fl_cmd;
      last_rises = fl_rises;
      fl_cmd     = '0;
      fl_bits    = 0;
      fl_rises   = 0;
    end else begin
      fl_rises = fl_rises + 1;
      if (fl_bits < CB) begin
        fl_cmd  = {fl_cmd[CB-2:0], mosi};
        fl_bits = fl_bits + 1;
      end
    end
  end

  always @(negedge sck or posedge cs_n) begin
    logic [7:0] b;
    if (cs_n) begin
      fl_dbit = 0;
    end else if (fl_bits >= CB) begin
      b       = mem_byte(fl_cmd[AW-1:0] + AW'(fl_dbit / 8));
      miso    = b[7 - (fl_dbit % 8)];
      fl_dbit = fl_dbit + 1;
    end
  end

  always @(negedge cs_n) cs_falls = cs_falls + 1;

  // ---------------- checking ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One burst. drop_at >= 0 drops rd_cont at that cycle count; otherwise
  // rd_cont drops after the valid pulse of byte n-2. poke issues a strobe mid-burst.
  task automatic run_read(input logic [AW-1:0] a, input int n, input int drop_at,
                          input bit poke, input string req);
    int cnt = 0;
    int k = 0;
    int cs_up = -1;
    int falls0 = cs_falls;
    logic [AW-1:0] ea;
    @(negedge clk);
    rd_start   = 1'b1;
    rd_cont    = 1'b1;
    start_addr = a;
    @(negedge clk);
    rd_start = 1'b0;
    check(busy && !cs_n, "R1", "busy/cs after accept", {busy, cs_n}, 2'b10);
    forever begin
      if (drop_at >= 0 && cnt == drop_at) rd_cont = 1'b0;
      if (poke && cnt == 30) begin
        rd_start   = 1'b1;
        start_addr = a ^ 24'h5A5A5A;
      end
      if (poke && cnt == 31) rd_start = 1'b0;
      if (cnt == T_DATA)
        check(byte_out == mem_byte(a) && !byte_vld, "R3", "first byte before valid",
              {byte_vld, byte_out}, {1'b0, mem_byte(a)});
      if (byte_vld) begin
        ea = a + AW'(k);
        check(cnt == T_VLD + 8 * k, "R4", "valid cycle", cnt, T_VLD + 8 * k);
        check(byte_out == mem_byte(ea), "R2", "byte data", byte_out, mem_byte(ea));
        check(byte_addr == ea, "R5", "byte address", byte_addr, ea);
        check(cs_n == (k == n - 1), "R9", "cs at valid", cs_n, k == n - 1);
        k++;
        if (drop_at < 0 && k == n - 1) rd_cont = 1'b0;
      end
      if (cs_n && cs_up < 0) cs_up = cnt;
      if (!busy) break;
      if (cnt > 4000) break;
      cnt++;
      @(negedge clk);
    end
    rd_cont = 1'b0;
    check(k == n, req, "byte count", k, n);
    check(cnt == T_VLD + 8 * (n - 1) + 1, "R9", "busy fall cycle", cnt, T_VLD + 8 * (n - 1) + 1);
    check(cs_up == T_VLD + 8 * (n - 1), "R9", "cs rise cycle", cs_up, T_VLD + 8 * (n - 1));
    check(last_cmd == {8'h03, a}, "R1", "command word", last_cmd, {8'h03, a});
    check(last_rises == CB + 8 * n, "R2", "sck rises", last_rises, CB + 8 * n);
    if (poke)
      check(cs_falls - falls0 == 1, "R11", "commands started", cs_falls - falls0, 1);
    repeat (20) @(negedge clk);
    ea = a + AW'(n - 1);
    check(byte_out == mem_byte(ea) && byte_addr == ea && !byte_vld, "R10", "hold after burst",
          {byte_addr, byte_out}, {ea, mem_byte(ea)});
  endtask

  task automatic t_reset();
    check(!busy && !byte_vld && cs_n && !mosi, "R12", "reset control",
          {busy, byte_vld, cs_n, mosi}, 4'b0010);
    check(byte_out == 8'h00 && byte_addr == '0, "R12", "reset data",
          {byte_addr, byte_out}, 0);
  endtask

  task automatic t_single_strobe();
    run_read(24'h001234, 1, 0, 1'b0, "R8");
  endtask

  task automatic t_single_early();
    run_read(24'h0ABC00, 1, 20, 1'b0, "R8");
    run_read(24'h0ABC10, 1, T_DATA - 1, 1'b0, "R8");
  endtask

  task automatic t_burst();
    run_read(24'h100000, 2, -1, 1'b0, "R7");
    run_read(24'h2000F0, 5, -1, 1'b0, "R7");
  endtask

  task automatic t_stream_wrap();
    run_read(24'hFFFFFE, 4, -1, 1'b0, "R5");
    run_read(24'h345678, 40, -1, 1'b0, "R6");
  endtask

  task automatic t_ignore_busy();
    run_read(24'h00C0DE, 3, -1, 1'b1, "R11");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_single_strobe();
    t_single_early();
    t_burst();
    t_stream_wrap();
    t_ignore_busy();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule